// File: doc/BRIEF.md
# Power-Down Freeze and Wake Controller

This block sits between a bank of input pins, the state registers of a logic array, and a bank of output drivers. When software configuration has enabled the feature and the power-down pin is raised, the block freezes everything together: the input values seen by the logic, the stored state, the output data and the output-enable bits. An output that was high-impedance stays high-impedance, and a driven output keeps driving its frozen level. When the pin drops, a fixed recovery interval runs with a busy flag raised before anything is released. If the feature is disabled, the power-down pin is just another logic input.

Each input pin also has a keeper, enabled per pin. A pin reports through a driven flag whether anything drives it. While the pin is undriven, the keeper supplies the last level that was seen while it was driven. An activity monitor raises a standby flag once the kept input values have been quiet for a set number of cycles. The flag drops as soon as any of them moves.

Top module: `pdhold_ctrl`

## Requirements
- R1: After reset `st_q` is 0 and `pd_active`, `busy` and `standby` are all 0.
- R2: When `pd_feature_en` is 0, a high `pd_pin` freezes nothing. `pd_as_input` equals `pd_pin`, `pin_eff` follows the live inputs, and `st_q` loads `st_next` on the next clock edge.
- R3: When `pd_feature_en` is 1, `pd_as_input` is 0 whatever `pd_pin` is.
- R4: From the cycle in which `pd_pin` and `pd_feature_en` are both high, `pin_eff` shows the keeper values captured at the last clock edge before that cycle. Input changes during the freeze, including one made in that same cycle, have no effect on `pin_eff`.
- R5: While frozen, `st_q` does not change, and `st_next` is ignored.
- R6: While frozen, `out_hold` and `oe_hold` keep the values captured at the last edge before the freeze. An output-enable bit that was 0 stays 0.
- R7: After `pd_pin` falls, `busy` is 1 for exactly RECOV_CYC cycles. During those cycles the inputs, state and outputs stay frozen, and `pd_active` is 0. When `busy` falls, the live values pass again, and `st_q` loads on the following edge.
- R8: If `pd_pin` rises again during recovery, the block returns to power-down on the next edge, with `pd_active` at 1 and `busy` at 0.
- R9: For a pin whose keeper is enabled (`keep_en` bit at 1) and whose `pin_drv` bit is 0, the value used is the `pin_raw` level captured at the last edge where `pin_drv` was 1. If the keeper is disabled, the value is `pin_raw` unchanged.
- R10: `standby` rises after IDLE_CYC consecutive clock edges with no change in the kept input values. It drops in the same cycle as any change.
- R11: `pd_active` is 1 in every cycle after an edge at which the power-down request, `pd_pin` AND `pd_feature_en`, was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pd_pin | input | 1 | Power-down request pin |
| pd_feature_en | input | 1 | Configuration bit that enables power-down |
| pin_raw | input | N_IN | Raw input pin levels |
| pin_drv | input | N_IN | Per-pin flag: 1 means the pin is being driven |
| keep_en | input | N_IN | Per-pin keeper enable |
| st_next | input | N_ST | Next-state values from the logic array |
| out_val | input | N_OUT | Output data from the logic array |
| out_oe | input | N_OUT | Output enables from the logic array |
| pin_eff | output | N_IN | Input values as seen by the logic array |
| pd_as_input | output | 1 | Power-down pin value as a logic input |
| st_q | output | N_ST | Stored state |
| out_hold | output | N_OUT | Output data to the drivers |
| oe_hold | output | N_OUT | Output enables to the drivers |
| pd_active | output | 1 | Block is in power-down |
| busy | output | 1 | Recovery interval is running |
| standby | output | 1 | Inputs have been idle |

## Verification
Two cases matter. First, a rise of the power-down pin can land in the same cycle as new input, state and output values. The bench drives both at the same falling edge and expects the frozen values to be the ones captured at the edge before, with none of the same-cycle updates. Second, a new power-down request can arrive partway through the recovery count. The bench raises the pin mid-recovery and expects power-down to win at the next edge, with `busy` cleared and the outputs still frozen.

// File: rtl/pdh_pkg.sv
package pdh_pkg;

  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_DOWN = 2'd1,
    PH_WAKE = 2'd2
  } pdh_phase_e;

  // keeper selection for one pin
  function automatic logic keeper_pick(input logic drv, input logic en,
                                       input logic raw, input logic kept);
    if (drv)     return raw;
    else if (en) return kept;
    else         return raw;
  endfunction

  // saturating idle counter step
  function automatic int unsigned idle_step(input int unsigned cnt,
                                            input logic chg,
                                            input int unsigned lim);
    if (chg)            return 0;
    else if (cnt < lim) return cnt + 1;
    else                return lim;
  endfunction

endpackage

// File: rtl/pdh_keeper.sv
module pdh_keeper #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_raw,
  input  logic [W-1:0] pin_drv,
  input  logic [W-1:0] keep_en,
  output logic [W-1:0] keep_val
);
  import pdh_pkg::*;

  logic [W-1:0] kept_q;

  for (genvar i = 0; i < W; i++) begin : g_pin
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          kept_q[i] <= 1'b0;
      else if (pin_drv[i]) kept_q[i] <= pin_raw[i];
    end
    assign keep_val[i] = keeper_pick(pin_drv[i], keep_en[i], pin_raw[i], kept_q[i]);
  end

endmodule

// File: rtl/pdh_pd_fsm.sv
module pdh_pd_fsm #(
  parameter int RECOV_CYC = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd_req,
  output logic freeze,
  output logic busy,
  output logic down
);
  import pdh_pkg::*;

  localparam int CW = (RECOV_CYC < 2) ? 1 : $clog2(RECOV_CYC + 1);

  pdh_phase_e phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_RUN: if (pd_req) phase_d = PH_DOWN;
      PH_DOWN: begin
        if (!pd_req) begin
          phase_d = PH_WAKE;
          cnt_d   = CW'(RECOV_CYC - 1);
        end
      end
      PH_WAKE: begin
        if (pd_req)                 phase_d = PH_DOWN;
        else if (cnt_q == '0)       phase_d = PH_RUN;
        else                        cnt_d   = cnt_q - 1'b1;
      end
      default: phase_d = PH_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_RUN;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign down   = (phase_q == PH_DOWN);
  assign busy   = (phase_q == PH_WAKE);
  assign freeze = pd_req || (phase_q != PH_RUN);

endmodule

// File: rtl/pdh_hold_bank.sv
module pdh_hold_bank #(
  parameter int W       = 8,
  parameter bit REG_OUT = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         freeze,
  input  logic [W-1:0] live,
  output logic [W-1:0] held
);

  logic [W-1:0] cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cap_q <= '0;
    else if (!freeze) cap_q <= live;
  end

  if (REG_OUT) begin : g_reg
    assign held = cap_q;
  end else begin : g_pass
    assign held = freeze ? cap_q : live;
  end

endmodule

// File: rtl/pdh_activity.sv
module pdh_activity #(
  parameter int W        = 8,
  parameter int IDLE_CYC = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] keep_val,
  output logic         change,
  output logic         standby
);
  import pdh_pkg::*;

  localparam int CW = (IDLE_CYC < 2) ? 1 : $clog2(IDLE_CYC + 1);

  logic [W-1:0]  prev_q;
  logic [CW-1:0] idle_q;

  assign change = |(keep_val ^ prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      idle_q <= '0;
    end else begin
      prev_q <= keep_val;
      idle_q <= CW'(idle_step(32'(idle_q), change, IDLE_CYC));
    end
  end

  assign standby = (idle_q == CW'(IDLE_CYC)) && !change;

endmodule

// File: rtl/pdhold_ctrl.sv
module pdhold_ctrl #(
  parameter int N_IN      = 8,
  parameter int N_ST      = 8,
  parameter int N_OUT     = 8,
  parameter int RECOV_CYC = 250,
  parameter int IDLE_CYC  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_pin,
  input  logic             pd_feature_en,
  input  logic [N_IN-1:0]  pin_raw,
  input  logic [N_IN-1:0]  pin_drv,
  input  logic [N_IN-1:0]  keep_en,
  input  logic [N_ST-1:0]  st_next,
  input  logic [N_OUT-1:0] out_val,
  input  logic [N_OUT-1:0] out_oe,
  output logic [N_IN-1:0]  pin_eff,
  output logic             pd_as_input,
  output logic [N_ST-1:0]  st_q,
  output logic [N_OUT-1:0] out_hold,
  output logic [N_OUT-1:0] oe_hold,
  output logic             pd_active,
  output logic             busy,
  output logic             standby
);

  logic             pd_req;
  logic             freeze;
  logic             change;
  logic [N_IN-1:0]  keep_val;

  assign pd_req      = pd_pin & pd_feature_en;
  assign pd_as_input = pd_feature_en ? 1'b0 : pd_pin;

  pdh_keeper #(.W(N_IN)) u_keeper (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .pin_drv(pin_drv),
    .keep_en(keep_en), .keep_val(keep_val)
  );

  pdh_pd_fsm #(.RECOV_CYC(RECOV_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pd_req(pd_req),
    .freeze(freeze), .busy(busy), .down(pd_active)
  );

  pdh_hold_bank #(.W(N_IN), .REG_OUT(1'b0)) u_in_bank (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .live(keep_val), .held(pin_eff)
  );

  pdh_hold_bank #(.W(N_ST), .REG_OUT(1'b1)) u_st_bank (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .live(st_next), .held(st_q)
  );

  pdh_hold_bank #(.W(N_OUT), .REG_OUT(1'b0)) u_out_bank (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .live(out_val), .held(out_hold)
  );

  pdh_hold_bank #(.W(N_OUT), .REG_OUT(1'b0)) u_oe_bank (
    .clk(clk), .rst_n(rst_n), .freeze(freeze), .live(out_oe), .held(oe_hold)
  );

  pdh_activity #(.W(N_IN), .IDLE_CYC(IDLE_CYC)) u_act (
    .clk(clk), .rst_n(rst_n), .keep_val(keep_val),
    .change(change), .standby(standby)
  );

endmodule

// File: rtl/pdhold_ctrl_chk.sv
module pdhold_ctrl_chk #(
  parameter int N_IN  = 8,
  parameter int N_ST  = 8,
  parameter int N_OUT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pd_pin,
  input logic             pd_feature_en,
  input logic             pd_as_input,
  input logic [N_IN-1:0]  pin_eff,
  input logic [N_ST-1:0]  st_q,
  input logic [N_OUT-1:0] out_hold,
  input logic [N_OUT-1:0] oe_hold,
  input logic             pd_active,
  input logic             busy,
  input logic             standby,
  input logic             change
);

  assert_pd_masked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pd_feature_en |-> !pd_as_input);

  assert_enter_down_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_pin && pd_feature_en) |=> pd_active);

  assert_state_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |=> $stable(st_q));

  assert_outputs_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && $past(pd_active)) |-> ($stable(oe_hold) && $stable(out_hold)));

  assert_inputs_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_active && $past(pd_active)) |-> $stable(pin_eff));

  assert_wake_follows_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pd_active) |-> busy);

  assert_phase_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && pd_active));

  assert_standby_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    change |-> !standby);

endmodule

bind pdhold_ctrl pdhold_ctrl_chk #(.N_IN(N_IN), .N_ST(N_ST), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .pd_feature_en(pd_feature_en),
  .pd_as_input(pd_as_input), .pin_eff(pin_eff), .st_q(st_q),
  .out_hold(out_hold), .oe_hold(oe_hold), .pd_active(pd_active),
  .busy(busy), .standby(standby), .change(change)
);

// File: tb/pdhold_ctrl_tb.sv
`timescale 1ns/1ps
module pdhold_ctrl_tb;

  localparam int NI = 8;
  localparam int NS = 8;
  localparam int NO = 8;
  localparam int RC = 5;
  localparam int IC = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          pd_pin, pd_feature_en;
  logic [NI-1:0] pin_raw, pin_drv, keep_en;
  logic [NS-1:0] st_next;
  logic [NO-1:0] out_val, out_oe;
  logic [NI-1:0] pin_eff;
  logic          pd_as_input;
  logic [NS-1:0] st_q;
  logic [NO-1:0] out_hold, oe_hold;
  logic          pd_active, busy, standby;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  pdhold_ctrl #(.N_IN(NI), .N_ST(NS), .N_OUT(NO), .RECOV_CYC(RC), .IDLE_CYC(IC)) u_dut (
    .clk(clk), .rst_n(rst_n), .pd_pin(pd_pin), .pd_feature_en(pd_feature_en),
    .pin_raw(pin_raw), .pin_drv(pin_drv), .keep_en(keep_en), .st_next(st_next),
    .out_val(out_val), .out_oe(out_oe), .pin_eff(pin_eff), .pd_as_input(pd_as_input),
    .st_q(st_q), .out_hold(out_hold), .oe_hold(oe_hold), .pd_active(pd_active),
    .busy(busy), .standby(standby)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; pd_pin = 1'b0; pd_feature_en = 1'b0;
    pin_raw = '0; pin_drv = '1; keep_en = '0;
    st_next = '0; out_val = '0; out_oe = '0;
    step(3);
    rst_n = 1'b1;
    #1;
    chk("R1 st_q", 32'(st_q), 0);
    chk("R1 pd_active", 32'(pd_active), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 standby", 32'(standby), 0);
  endtask

  task automatic t_disabled();
    step(1);
    pd_feature_en = 1'b0; pd_pin = 1'b1; pin_raw = 8'h5A; st_next = 8'hA5;
    #1;
    chk("R2 pd_as_input", 32'(pd_as_input), 1);
    chk("R2 pin_eff live", 32'(pin_eff), 32'h5A);
    step(1);
    chk("R2 no pd_active", 32'(pd_active), 0);
    chk("R2 st_q loads", 32'(st_q), 32'hA5);
    pd_pin = 1'b0;
  endtask

  task automatic t_freeze();
    pin_raw = 8'h3C; st_next = 8'h11; out_val = 8'hF0; out_oe = 8'h0F;
    step(1);
    // same-cycle change together with the power-down rise
    pd_feature_en = 1'b1; pd_pin = 1'b1;
    pin_raw = 8'hC3; st_next = 8'h22; out_val = 8'h0F; out_oe = 8'hF0;
    #1;
    chk("R3 pd masked", 32'(pd_as_input), 0);
    chk("R4 same-cycle input ignored", 32'(pin_eff), 32'h3C);
    chk("R6 out same-cycle", 32'(out_hold), 32'hF0);
    step(1);
    chk("R11 pd_active", 32'(pd_active), 1);
    chk("R5 st_q held", 32'(st_q), 32'h11);
    pin_raw = 8'h99; st_next = 8'h33;
    step(3);
    pin_raw = 8'hC3; st_next = 8'h22;
    #1;
    chk("R4 pin_eff held", 32'(pin_eff), 32'h3C);
    chk("R5 st_q still held", 32'(st_q), 32'h11);
    chk("R6 out_hold held", 32'(out_hold), 32'hF0);
    chk("R6 hi-Z bits stay off", 32'(oe_hold), 32'h0F);
  endtask

  task automatic t_recover();
    pd_pin = 1'b0;
    step(1);
    chk("R7 busy start", 32'(busy), 1);
    chk("R7 pd_active low", 32'(pd_active), 0);
    step(RC - 1);
    chk("R7 busy last cycle", 32'(busy), 1);
    chk("R7 input held in recovery", 32'(pin_eff), 32'h3C);
    step(1);
    chk("R7 busy done", 32'(busy), 0);
    chk("R7 input released", 32'(pin_eff), 32'hC3);
    chk("R7 oe released", 32'(oe_hold), 32'hF0);
    chk("R7 st_q before load", 32'(st_q), 32'h11);
    step(1);
    chk("R7 st_q loads", 32'(st_q), 32'h22);
  endtask

  task automatic t_reenter();
    pd_pin = 1'b1;
    step(2);
    pd_pin = 1'b0;
    step(3);
    chk("R8 in recovery", 32'(busy), 1);
    pd_pin = 1'b1;
    step(1);
    chk("R8 back down", 32'(pd_active), 1);
    chk("R8 busy cleared", 32'(busy), 0);
    pd_pin = 1'b0;
    step(RC + 2);
  endtask

  task automatic t_keeper();
    pd_feature_en = 1'b0;
    keep_en = 8'h01;
    pin_raw = 8'h03;
    step(1);
    pin_drv = 8'hFC; pin_raw = 8'h00;
    #1;
    chk("R9 kept high", 32'(pin_eff[0]), 1);
    chk("R9 disabled passes raw", 32'(pin_eff[1]), 0);
    step(2);
    chk("R9 still kept", 32'(pin_eff[0]), 1);
    pin_drv = 8'hFF;
    #1;
    chk("R9 driven again", 32'(pin_eff[0]), 0);
  endtask

  task automatic t_standby();
    pin_raw = 8'h44;
    step(IC);
    chk("R10 not yet idle", 32'(standby), 0);
    step(1);
    chk("R10 standby up", 32'(standby), 1);
    pin_raw = 8'h45;
    #1;
    chk("R10 standby drops", 32'(standby), 0);
  endtask

  initial begin
    #(4 * 100000);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_disabled();
    t_freeze();
    t_recover();
    t_reenter();
    t_keeper();
    t_standby();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule